// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This unit multiplies two signed operands and adds the product to a double-width accumulator. The accumulator is presented as a high half and a low half, each one operand wide. A single start strobe launches one operation. About three cycles later the accumulator holds the new sum and a one-cycle done pulse marks the update. A clear input empties the accumulator.

There are two operand modes. The wide mode multiplies the full operands. The narrow mode multiplies only the lower half of each operand, sign-extended. An optional saturation step runs after the addition, and its rule depends on the mode:
- Wide mode: the high half is trimmed by bit forcing, so that the result stays within a reduced width.
- Narrow mode: the sum is clamped to the range of one operand word, and a value of 1 is written into the high half to mark that clamping took place.

Top module: `mac_sat_unit`

## Requirements
- R1: With `mode`=0 (wide), the product of `op_a` and `op_b` as signed DATA_W-bit values is added to {`acc_hi`,`acc_lo`} in 2·DATA_W-bit two's complement. With `sat_en`=0 the sum wraps and is stored unchanged.
- R2: With `mode`=1 (narrow), only bits HALF_W-1:0 of each operand are used, sign-extended; the upper operand bits have no effect on the result (HALF_W = DATA_W/2).
- R3: Wide mode with `sat_en`=1: a negative sum gets `acc_hi` bits DATA_W-1:HALF_W forced to 1; a non-negative sum keeps only `acc_hi` bits HALF_W-2:0, the rest cleared; `acc_lo` is the plain sum in both cases.
- R4: Narrow mode with `sat_en`=1: a sum below -2^(DATA_W-1) stores `acc_hi`=1 and `acc_lo`=2^(DATA_W-1) (sign bit only).
- R5: Narrow mode with `sat_en`=1: a sum above 2^(DATA_W-1)-1 stores `acc_hi`=1 and `acc_lo`=2^(DATA_W-1)-1.
- R6: Narrow mode with `sat_en`=1: a sum inside the signed DATA_W-bit range is stored as the full 2·DATA_W-bit sum, high half included.
- R7: A start sampled at rising edge k while idle and with `clr` low updates the accumulator at edge k+2. `done` is high for exactly the one cycle that follows that edge, and the accumulator does not change at any other time except on clear.
- R8: A start sampled while an operation is in flight is ignored: it neither adds a product nor causes an extra done pulse.
- R9: `clr` zeroes both halves at the next edge. It wins over a simultaneous start, and it abandons an operation in flight, which then produces no done and no update.
- R10: After reset both accumulator halves are zero and `done` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch one multiply-accumulate |
| clr | input | 1 | Zero the accumulator, cancel work in flight |
| mode | input | 1 | 0 = wide operands, 1 = narrow (lower half) operands |
| sat_en | input | 1 | Enable mode-dependent saturation |
| op_a | input | DATA_W | First operand |
| op_b | input | DATA_W | Second operand |
| acc_hi | output | DATA_W | Upper half of the accumulator |
| acc_lo | output | DATA_W | Lower half of the accumulator |
| done | output | 1 | One-cycle pulse when the accumulator has been updated |

## Verification
The bench builds the unit with DATA_W=8, which gives a 16-bit accumulator and 4-bit narrow operands. With this setting the narrow-mode operand space is swept completely, with changing junk in the upper operand bits. The wide-mode space is swept with every value of the first operand against a strided set of the second, both with and without saturation. Because the accumulator is only 16 bits wide, running sums quickly cross the 8-bit clamp limits and the 12-bit trim boundary. As a result, the wrap, clamp, in-range and bit-forcing paths are all reached many times and compared with an arithmetic model.

// File: rtl/mac_pkg.sv
package mac_pkg;
    typedef enum logic {
        MODE_WIDE   = 1'b0,
        MODE_NARROW = 1'b1
    } mac_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_ACC  = 2'd2
    } mac_state_e;
endpackage

// File: rtl/mac_mult.sv
module mac_mult
    import mac_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  mac_mode_e             mode,
    input  logic [DATA_W-1:0]     op_a,
    input  logic [DATA_W-1:0]     op_b,
    output logic [2*DATA_W-1:0]   prod
);
    localparam int HALF_W = DATA_W / 2;
    localparam int ACC_W  = 2 * DATA_W;

    typedef struct packed {
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic [ACC_W-1:0]  prod;
    } mult_reg_t;

    mult_reg_t r_d, r_q;

    function automatic logic [DATA_W-1:0] pick(input logic [DATA_W-1:0] v,
                                               input mac_mode_e m);
        if (m == MODE_NARROW)
            return {{(DATA_W-HALF_W){v[HALF_W-1]}}, v[HALF_W-1:0]};
        return v;
    endfunction

    logic [ACC_W-1:0] a_ext, b_ext;

    always_comb begin
        r_d   = r_q;
        a_ext = {{DATA_W{r_q.a[DATA_W-1]}}, r_q.a};
        b_ext = {{DATA_W{r_q.b[DATA_W-1]}}, r_q.b};
        if (load) begin
            r_d.a = pick(op_a, mode);
            r_d.b = pick(op_b, mode);
        end
        r_d.prod = a_ext * b_ext;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign prod = r_q.prod;
endmodule

// File: rtl/mac_clip.sv
module mac_clip
    import mac_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [2*DATA_W-1:0] sum,
    input  mac_mode_e           mode,
    input  logic                sat_en,
    output logic [2*DATA_W-1:0] res
);
    localparam int HALF_W = DATA_W / 2;
    localparam int ACC_W  = 2 * DATA_W;
    localparam logic [DATA_W-1:0] KEEP_MASK =
        {{(DATA_W-HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] WORD_MIN = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] WORD_MAX = {1'b0, {(DATA_W-1){1'b1}}};

    logic [DATA_W:0] upper;
    logic            fits;

    always_comb begin
        upper = sum[ACC_W-1:DATA_W-1];
        fits  = (upper == '0) || (upper == '1);
        res   = sum;
        if (sat_en) begin
            if (mode == MODE_WIDE) begin
                if (sum[ACC_W-1])
                    res[ACC_W-1:DATA_W+HALF_W] = '1;
                else
                    res[ACC_W-1:DATA_W] = sum[ACC_W-1:DATA_W] & KEEP_MASK;
            end else if (!fits) begin
                res[ACC_W-1:DATA_W] = DATA_W'(1);
                res[DATA_W-1:0]     = sum[ACC_W-1] ? WORD_MIN : WORD_MAX;
            end
        end
    end
endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit
    import mac_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              clr,
    input  logic              mode,
    input  logic              sat_en,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic [DATA_W-1:0] acc_hi,
    output logic [DATA_W-1:0] acc_lo,
    output logic              done
);
    localparam int HALF_W = DATA_W / 2;
    localparam int ACC_W  = 2 * DATA_W;

    typedef struct packed {
        mac_state_e       state;
        mac_mode_e        mode;
        logic             sat;
        logic [ACC_W-1:0] acc;
        logic             done;
    } unit_reg_t;

    unit_reg_t u_d, u_q;

    logic             accept;
    logic [ACC_W-1:0] prod;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] clipped;

    assign accept = (u_q.state == ST_IDLE) && start && !clr;
    assign sum    = u_q.acc + prod;

    mac_mult #(.DATA_W(DATA_W)) u_mult (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .mode  (mac_mode_e'(mode)),
        .op_a  (op_a),
        .op_b  (op_b),
        .prod  (prod)
    );

    mac_clip #(.DATA_W(DATA_W)) u_clip (
        .sum    (sum),
        .mode   (u_q.mode),
        .sat_en (u_q.sat),
        .res    (clipped)
    );

    always_comb begin
        u_d      = u_q;
        u_d.done = 1'b0;
        if (clr) begin
            u_d.acc   = '0;
            u_d.state = ST_IDLE;
        end else begin
            unique case (u_q.state)
                ST_IDLE: if (start) begin
                    u_d.state = ST_MUL;
                    u_d.mode  = mac_mode_e'(mode);
                    u_d.sat   = sat_en;
                end
                ST_MUL:  u_d.state = ST_ACC;
                ST_ACC: begin
                    u_d.acc   = clipped;
                    u_d.done  = 1'b1;
                    u_d.state = ST_IDLE;
                end
                default: u_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) u_q <= '0;
        else        u_q <= u_d;
    end

    assign acc_hi = u_q.acc[ACC_W-1:DATA_W];
    assign acc_lo = u_q.acc[DATA_W-1:0];
    assign done   = u_q.done;

    // R7: completion is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: outside completion and clear the accumulator holds
    p_acc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (u_q.state != ST_ACC) && !clr |=> $stable({acc_hi, acc_lo}));

    // R8: a busy unit never re-enters the multiply step
    p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (u_q.state != ST_IDLE) |=> (u_q.state != ST_MUL));

    // R9: clear empties the accumulator and suppresses done
    p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_hi == '0) && (acc_lo == '0) && !done);

    // R3: wide saturation leaves the high half forced or trimmed
    p_wide_trim_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (u_q.state == ST_ACC) && !clr && u_q.sat && (u_q.mode == MODE_WIDE)
        |=> (acc_hi[DATA_W-1:HALF_W] == '1) || (acc_hi[DATA_W-1:HALF_W-1] == '0));

    // R4/R5/R6: narrow saturation leaves either a marker or a sign extension
    p_narrow_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (u_q.state == ST_ACC) && !clr && u_q.sat && (u_q.mode == MODE_NARROW)
        |=> (acc_hi == DATA_W'(1)) || (acc_hi == {DATA_W{acc_lo[DATA_W-1]}}));
endmodule

// File: tb/mac_sat_unit_test.sv
`timescale 1ns/1ps
module mac_sat_unit_test;
    localparam int DW = 8;
    localparam int AW = 16;

    logic clk = 1'b0;
    logic rst_n, start, clr, mode, sat_en;
    logic [DW-1:0] op_a, op_b;
    logic [DW-1:0] acc_hi, acc_lo;
    logic done;

    int checks = 0;
    int errors = 0;
    logic [AW-1:0] model_acc;

    always #4 clk = ~clk;

    mac_sat_unit #(.DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .clr(clr), .mode(mode),
        .sat_en(sat_en), .op_a(op_a), .op_b(op_b),
        .acc_hi(acc_hi), .acc_lo(acc_lo), .done(done)
    );

    function automatic logic [AW-1:0] step(input logic [AW-1:0] acc,
        input logic [DW-1:0] a, input logic [DW-1:0] b,
        input logic m, input logic s);
        logic signed [AW-1:0] pa, pb, sm;
        logic [DW-1:0] hi;
        int v;
        pa = m ? AW'($signed(a[3:0])) : AW'($signed(a));
        pb = m ? AW'($signed(b[3:0])) : AW'($signed(b));
        sm = $signed(acc) + pa * pb;
        if (!s) return sm;
        if (!m) begin
            hi = sm[15:8];
            hi = sm[15] ? (hi | 8'hF0) : (hi & 8'h07);
            return {hi, sm[7:0]};
        end
        v = int'(sm);
        if (v < -128) return 16'h0180;
        if (v > 127)  return 16'h017F;
        return sm;
    endfunction

    task automatic chk(input string req, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_clear();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        model_acc = '0;
        chk("R9 clear", {acc_hi, acc_lo}, 16'h0000);
    endtask

    task automatic do_op(input logic [DW-1:0] a, input logic [DW-1:0] b,
                         input logic m, input logic s, input string req);
        @(negedge clk);
        op_a = a; op_b = b; mode = m; sat_en = s; start = 1'b1;
        @(negedge clk); start = 1'b0; op_a = ~a; op_b = ~b;
        @(negedge clk);
        @(negedge clk);
        model_acc = step(model_acc, a, b, m, s);
        chk({req, " done"}, {15'd0, done}, 16'd1);
        chk(req, {acc_hi, acc_lo}, model_acc);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; clr = 1'b0; mode = 1'b0; sat_en = 1'b0;
        op_a = '0; op_b = '0; model_acc = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        chk("R10 reset acc", {acc_hi, acc_lo}, 16'h0000);
        chk("R10 reset done", {15'd0, done}, 16'd0);

        // R7: exact latency and single-cycle pulse
        @(negedge clk); op_a = 8'd3; op_b = 8'd5; mode = 1'b0; sat_en = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R7 no done early", {15'd0, done}, 16'd0);
        @(negedge clk);
        chk("R7 acc not yet", {acc_hi, acc_lo}, 16'h0000);
        @(negedge clk);
        chk("R7 done", {15'd0, done}, 16'd1);
        chk("R7 acc", {acc_hi, acc_lo}, 16'd15);
        @(negedge clk);
        chk("R7 done drops", {15'd0, done}, 16'd0);
        model_acc = 16'd15;

        // R8: start held through the busy cycles
        do_clear();
        @(negedge clk); op_a = 8'd6; op_b = 8'd7; mode = 1'b0; start = 1'b1;
        @(negedge clk); op_a = 8'd100; op_b = 8'd100;
        @(negedge clk);
        @(negedge clk); start = 1'b0;
        chk("R8 single result", {acc_hi, acc_lo}, 16'd42);
        @(negedge clk);
        chk("R8 no extra done", {15'd0, done}, 16'd0);
        repeat (3) @(negedge clk);
        chk("R8 acc unchanged", {acc_hi, acc_lo}, 16'd42);

        // R9: clear beats start, and cancels work in flight
        @(negedge clk); clr = 1'b1; start = 1'b1; op_a = 8'd9; op_b = 8'd9;
        @(negedge clk); clr = 1'b0; start = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 start with clear", {acc_hi, acc_lo}, 16'h0000);
        @(negedge clk); op_a = 8'd9; op_b = 8'd9; start = 1'b1;
        @(negedge clk); start = 1'b0; clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        chk("R9 cancel no done", {15'd0, done}, 16'd0);
        @(negedge clk);
        chk("R9 cancel no done later", {15'd0, done}, 16'd0);
        chk("R9 cancel acc", {acc_hi, acc_lo}, 16'h0000);
        model_acc = '0;

        // R1: wide wrap
        do_op(8'h7F, 8'h7F, 1'b0, 1'b0, "R1 wide");
        chk("R1 value", {acc_hi, acc_lo}, 16'h3F01);
        do_op(8'h80, 8'h80, 1'b0, 1'b0, "R1 wide");
        do_op(8'h80, 8'h80, 1'b0, 1'b0, "R1 wide");
        chk("R1 wrap", {acc_hi, acc_lo}, 16'hBF01);

        // R2: upper operand bits ignored in narrow mode
        do_clear();
        do_op(8'hF3, 8'h52, 1'b1, 1'b0, "R2 narrow");
        chk("R2 value", {acc_hi, acc_lo}, 16'd6);
        do_op(8'h0F, 8'hA2, 1'b1, 1'b0, "R2 narrow sign");
        chk("R2 sign value", {acc_hi, acc_lo}, 16'd4);

        // R3: wide trimming
        do_clear();
        do_op(8'h7F, 8'h7F, 1'b0, 1'b1, "R3 wide pos");
        chk("R3 pos trim", {acc_hi, acc_lo}, 16'h0701);
        do_clear();
        do_op(8'h80, 8'h7F, 1'b0, 1'b1, "R3 wide neg");
        chk("R3 neg force", {acc_hi, acc_lo}, 16'hF080);

        // R5, R6: narrow upward clamp
        do_clear();
        do_op(8'h07, 8'h07, 1'b1, 1'b1, "R6 narrow in range");
        chk("R6 value", {acc_hi, acc_lo}, 16'h0031);
        do_op(8'h07, 8'h07, 1'b1, 1'b1, "R6 narrow in range");
        do_op(8'h07, 8'h07, 1'b1, 1'b1, "R5 narrow high");
        chk("R5 clamp", {acc_hi, acc_lo}, 16'h017F);

        // R4, R6: narrow downward clamp
        do_clear();
        do_op(8'h08, 8'h07, 1'b1, 1'b1, "R6 narrow negative");
        chk("R6 full high half", {acc_hi, acc_lo}, 16'hFFC8);
        do_op(8'h08, 8'h07, 1'b1, 1'b1, "R6 narrow negative");
        do_op(8'h08, 8'h07, 1'b1, 1'b1, "R4 narrow low");
        chk("R4 clamp", {acc_hi, acc_lo}, 16'h0180);

        // R2/R4/R5/R6: exhaustive narrow sweep, both saturation settings
        for (int s = 0; s < 2; s++) begin
            do_clear();
            for (int ia = 0; ia < 16; ia++) begin
                for (int ib = 0; ib < 16; ib++) begin
                    do_op({4'(ia * 5 + ib), 4'(ia)}, {4'(ib * 3 + 7), 4'(ib)},
                          1'b1, s[0], "R2 sweep");
                end
                if (ia % 4 == 3) do_clear();
            end
        end

        // R1/R3: strided wide sweep, both saturation settings
        for (int s = 0; s < 2; s++) begin
            do_clear();
            for (int ia = 0; ia < 256; ia++) begin
                for (int ib = 0; ib < 256; ib += 7) begin
                    do_op(8'(ia), 8'(ib), 1'b0, s[0], s[0] ? "R3 sweep" : "R1 sweep");
                end
                if (ia % 8 == 7) do_clear();
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule